// File: doc/BRIEF.md
# Three-Level Neutral-Point-Clamped Bridge Space-Vector Modulator

This block drives a single-phase H-bridge made of two three-level neutral-point-clamped legs. Each carrier period it takes a signed bridge-voltage reference and the two split dc-link capacitor voltages, and works out which of four sections the reference falls in. It then splits the period between the two neighbouring bridge vectors by volt-second balance and emits the upper/middle/lower state of each leg as four switch gates per leg. Dead time and gate drivers sit outside.

Half-level vectors can be produced by two redundant bridge states, and each state charges or discharges a different capacitor. The block picks one from the sign of the capacitor imbalance and the grid-current direction, so that the neutral point is pulled back toward the midpoint. The pick is held in a register that only changes while no half-level vector is on the bridge. This means a vector never changes its redundant state partway through its dwell.

The carrier period is `CAR_LEN` clock cycles; the default gives about 30 kHz from a 50 MHz clock. The reference and the section are sampled once per period.

Top module: `npc_svm_mod`

## Requirements
- R1: While reset is held and for the whole first carrier period after it, both legs are in the middle state (gates 4'b0110) and `frame_start` is 1 in the first cycle of the period.
- R2: Gate bit k drives switch k+1 of a leg, counting from the positive rail. Upper state = 4'b0011, middle = 4'b0110, lower = 4'b1100; no other gate pattern ever appears.
- R3: The section is chosen as follows, with Vdc = vc1+vc2, half = Vdc>>1 and u = uref:
  - Section I (half-positive then full-positive, leg A upper and leg B lower) when u > half.
  - Section II (zero then half-positive) when 0 <= u <= half.
  - Section III (zero then half-negative) when -half <= u < 0.
  - Section IV (half-negative then full-negative, leg A lower and leg B upper) when u < -half.
  - The zero vector is middle/middle.
- R4: In each period the lower-level vector of the section is applied for the first T1 cycles and the other vector for the rest.
  - T1 = floor(|Vmax - u| * CAR_LEN / half), where Vmax is Vdc, half, -half or -Vdc for sections I to IV.
  - T1 is clamped to 0 when the reference lies beyond Vmax, and limited to CAR_LEN.
  - T1 = CAR_LEN when half is 0.
- R5: The half-positive vector is (A upper, B middle) or (A middle, B lower). The second is chosen exactly when (vc1 > vc2) equals `cur_pos` (1 = current flowing from terminal A to B).
- R6: The half-negative vector is (A middle, B upper) or (A lower, B middle). The second is chosen exactly when (vc1 > vc2) differs from `cur_pos`.
- R7: Equal capacitor voltages select as if vc1 < vc2.
- R8: While a half-level vector is applied, its redundant choice does not change, whatever the inputs do. The choice follows the inputs again once a non-half vector is applied.
- R9: The section and T1 are sampled from the inputs in the last cycle of a period and stay fixed for the whole next period, so reference changes within a period take effect only in the next one.
- R10: `frame_start` is 1 in exactly one cycle of every CAR_LEN cycles, the first cycle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uref | input | VW+2 | Signed bridge-voltage reference |
| vc1 | input | VW | Upper capacitor voltage, unsigned |
| vc2 | input | VW | Lower capacitor voltage, unsigned |
| cur_pos | input | 1 | 1 when grid current flows from terminal A to B |
| gate_a | output | 4 | Switch gates of leg A, bit 0 = switch nearest positive rail |
| gate_b | output | 4 | Switch gates of leg B |
| frame_start | output | 1 | High in the first cycle of each carrier period |

## Verification
Two functions can fall in the same cycle:
- The redundant-state register may want to follow new capacitor or current inputs.
- The dwell sequencer may be holding a half-level vector on the bridge.

The bench provokes this by flipping the current direction in the middle of a half-level dwell, in both section II and section III. It requires the rest of that dwell to keep the old state, and the same vector in the next period to take the new one. A full sweep of the reference across and beyond both rails, for several capacitor splits including an equal and an odd sum, covers every section boundary and clamp. Each output cycle of the sweep is compared with a dwell count found by searching multiples of half.

// File: rtl/npc_mod_pkg.sv
package npc_mod_pkg;
  typedef enum logic [1:0] {LEG_P = 2'd0, LEG_O = 2'd1, LEG_N = 2'd2} leg_t;
  typedef enum logic [1:0] {SEC_1 = 2'd0, SEC_2 = 2'd1, SEC_3 = 2'd2, SEC_4 = 2'd3} sec_t;
  typedef enum logic [2:0] {VEC_ZERO, VEC_HPOS, VEC_HNEG, VEC_FPOS, VEC_FNEG} vec_t;

  // switch k+1 of a leg is gate bit k, counted from the positive rail
  function automatic logic [3:0] leg_gates(input leg_t s);
    case (s)
      LEG_P:   return 4'b0011;
      LEG_N:   return 4'b1100;
      default: return 4'b0110;
    endcase
  endfunction
endpackage

// File: rtl/npc_sector_calc.sv
module npc_sector_calc
  import npc_mod_pkg::*;
#(
  parameter int VW = 10,
  parameter int CAR_LEN = 1666,
  parameter int CW = 11
) (
  input  logic signed [VW+1:0] uref,
  input  logic [VW-1:0]        vc1,
  input  logic [VW-1:0]        vc2,
  output sec_t                 sec,
  output logic [CW-1:0]        t1
);
  localparam int SW = VW + 3;
  localparam int PW = SW + CW;

  logic signed [SW-1:0] u_s, vdc_s, half_s, vmax_s, mag_s;

  // lower-level dwell by volt-second balance, clamped to one period
  function automatic logic [CW-1:0] dwell_len(input logic signed [SW-1:0] mag,
                                              input logic signed [SW-1:0] half);
    logic [PW-1:0] q;
    q = '0;
    if (half == '0) return CW'(CAR_LEN);
    if (mag[SW-1]) return '0;
    q = (PW'($unsigned(mag)) * PW'(CAR_LEN)) / PW'($unsigned(half));
    if (q > PW'(CAR_LEN)) return CW'(CAR_LEN);
    return q[CW-1:0];
  endfunction

  always_comb begin
    u_s    = {uref[VW+1], uref};
    vdc_s  = $signed({3'b000, vc1}) + $signed({3'b000, vc2});
    half_s = vdc_s >>> 1;
    if (!u_s[SW-1]) sec = (u_s > half_s) ? SEC_1 : SEC_2;
    else            sec = (u_s < -half_s) ? SEC_4 : SEC_3;
    case (sec)
      SEC_1:   vmax_s = vdc_s;
      SEC_2:   vmax_s = half_s;
      SEC_3:   vmax_s = -half_s;
      default: vmax_s = -vdc_s;
    endcase
    mag_s = (sec == SEC_1 || sec == SEC_2) ? (vmax_s - u_s) : (u_s - vmax_s);
  end

  assign t1 = dwell_len(mag_s, half_s);
endmodule

// File: rtl/npc_vector_seq.sv
module npc_vector_seq
  import npc_mod_pkg::*;
#(
  parameter int CAR_LEN = 1666,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sec_t          sec_in,
  input  logic [CW-1:0] t1_in,
  output vec_t          cur_vec,
  output logic          frame_start
);
  logic [CW-1:0] cnt, t1_q;
  sec_t          sec_q;
  logic          period_end, lower_phase;

  assign period_end  = (cnt == CW'(CAR_LEN - 1));
  assign frame_start = (cnt == '0);
  assign lower_phase = (cnt < t1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sec_q <= SEC_2;
      t1_q  <= CW'(CAR_LEN);
    end else if (period_end) begin
      cnt   <= '0;
      sec_q <= sec_in;
      t1_q  <= t1_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (sec_q)
      SEC_1:   cur_vec = lower_phase ? VEC_HPOS : VEC_FPOS;
      SEC_2:   cur_vec = lower_phase ? VEC_ZERO : VEC_HPOS;
      SEC_3:   cur_vec = lower_phase ? VEC_ZERO : VEC_HNEG;
      default: cur_vec = lower_phase ? VEC_HNEG : VEC_FNEG;
    endcase
  end

  p_t1_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t1_q <= CW'(CAR_LEN));

  p_latch_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> ($stable(sec_q) && $stable(t1_q)));

  generate
    if (CAR_LEN > 1) begin : g_frame_chk
      p_frame_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    end
  endgenerate
endmodule

// File: rtl/npc_redundant_sel.sv
module npc_redundant_sel
  import npc_mod_pkg::*;
#(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vec_t          cur_vec,
  input  logic [VW-1:0] vc1,
  input  logic [VW-1:0] vc2,
  input  logic          cur_pos,
  output logic          sp_on,
  output logic          sn_no
);
  logic hi1, half_busy;

  assign hi1       = (vc1 > vc2);   // equality falls to the vc1 < vc2 side
  assign half_busy = (cur_vec == VEC_HPOS) || (cur_vec == VEC_HNEG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_on <= 1'b0;
      sn_no <= 1'b0;
    end else if (!half_busy) begin
      sp_on <= (hi1 == cur_pos);
      sn_no <= (hi1 != cur_pos);
    end
  end
endmodule

// File: rtl/npc_svm_mod.sv
module npc_svm_mod
  import npc_mod_pkg::*;
#(
  parameter int VW = 10,
  parameter int CAR_LEN = 1666
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [VW+1:0] uref,
  input  logic [VW-1:0]        vc1,
  input  logic [VW-1:0]        vc2,
  input  logic                 cur_pos,
  output logic [3:0]           gate_a,
  output logic [3:0]           gate_b,
  output logic                 frame_start
);
  localparam int CW = $clog2(CAR_LEN + 1);

  sec_t          sec_w;
  logic [CW-1:0] t1_w;
  vec_t          cur_vec;
  logic          sp_on, sn_no;
  leg_t          legs [2];
  logic [1:0][3:0] gates_w;
  logic          half_pos, half_neg, half_any;

  npc_sector_calc #(.VW(VW), .CAR_LEN(CAR_LEN), .CW(CW)) u_sec (
    .uref(uref), .vc1(vc1), .vc2(vc2), .sec(sec_w), .t1(t1_w));

  npc_vector_seq #(.CAR_LEN(CAR_LEN), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sec_in(sec_w), .t1_in(t1_w),
    .cur_vec(cur_vec), .frame_start(frame_start));

  npc_redundant_sel #(.VW(VW)) u_red (
    .clk(clk), .rst_n(rst_n), .cur_vec(cur_vec), .vc1(vc1), .vc2(vc2),
    .cur_pos(cur_pos), .sp_on(sp_on), .sn_no(sn_no));

  always_comb begin
    case (cur_vec)
      VEC_HPOS: begin legs[0] = sp_on ? LEG_O : LEG_P; legs[1] = sp_on ? LEG_N : LEG_O; end
      VEC_HNEG: begin legs[0] = sn_no ? LEG_N : LEG_O; legs[1] = sn_no ? LEG_O : LEG_P; end
      VEC_FPOS: begin legs[0] = LEG_P; legs[1] = LEG_N; end
      VEC_FNEG: begin legs[0] = LEG_N; legs[1] = LEG_P; end
      default:  begin legs[0] = LEG_O; legs[1] = LEG_O; end
    endcase
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_leg
      assign gates_w[g] = leg_gates(legs[g]);
    end
  endgenerate

  assign gate_a = gates_w[0];
  assign gate_b = gates_w[1];

  assign half_pos = (cur_vec == VEC_HPOS);
  assign half_neg = (cur_vec == VEC_HNEG);
  assign half_any = half_pos || half_neg;

  p_gate_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b0011 || gate_a == 4'b0110 || gate_a == 4'b1100) &&
    (gate_b == 4'b0011 || gate_b == 4'b0110 || gate_b == 4'b1100));

  p_hold_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((half_pos && $past(half_pos)) || (half_neg && $past(half_neg))) |->
      (gate_a == $past(gate_a) && gate_b == $past(gate_b)));

  p_pick_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_pos && !$past(half_any)) |->
      ((gate_b == 4'b1100) == ($past(vc1 > vc2) == $past(cur_pos))));

  p_pick_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half_neg && !$past(half_any)) |->
      ((gate_a == 4'b1100) == ($past(vc1 > vc2) != $past(cur_pos))));
endmodule

// File: tb/sim_npc_svm_mod.sv
module sim_npc_svm_mod;
  localparam int VW = 10;
  localparam int TS = 16;
  localparam int GP = 3, GO = 6, GN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [VW+1:0] uref = '0;
  logic [VW-1:0] vc1 = '0, vc2 = '0;
  logic cur_pos = 1'b0;
  logic [3:0] gate_a, gate_b;
  logic frame_start;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  npc_svm_mod #(.VW(VW), .CAR_LEN(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .uref(uref), .vc1(vc1), .vc2(vc2),
    .cur_pos(cur_pos), .gate_a(gate_a), .gate_b(gate_b), .frame_start(frame_start));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // dwell count found by search: largest k <= TS with k*half <= mag*TS
  function automatic int dwell(input int u, input int a, input int b, output int sec);
    int vdc, half, vmax, mag, k;
    vdc = a + b; half = vdc / 2;
    if (u >= 0) sec = (u > half) ? 1 : 2;
    else        sec = (u < -half) ? 4 : 3;
    vmax = (sec == 1) ? vdc : (sec == 2) ? half : (sec == 3) ? -half : -vdc;
    mag = (sec <= 2) ? vmax - u : u - vmax;
    if (half == 0) return TS;
    if (mag < 0) return 0;
    k = 0;
    while (k < TS && (k + 1) * half <= mag * TS) k++;
    return k;
  endfunction

  // expected gates {A,B} packed as A*16+B at period offset c
  function automatic int exp_pair(input int c, input int u, input int a, input int b, input bit ip);
    int sec, t1, kind;
    bit on_pick, no_pick;
    t1 = dwell(u, a, b, sec);
    on_pick = (a > b) ? ip : !ip;
    no_pick = (a > b) ? !ip : ip;
    case (sec)
      1: kind = (c < t1) ? 1 : 3;
      2: kind = (c < t1) ? 0 : 1;
      3: kind = (c < t1) ? 0 : 2;
      default: kind = (c < t1) ? 2 : 4;
    endcase
    case (kind)
      1: return on_pick ? GO * 16 + GN : GP * 16 + GO;
      2: return no_pick ? GN * 16 + GO : GO * 16 + GP;
      3: return GP * 16 + GN;
      4: return GN * 16 + GP;
      default: return GO * 16 + GO;
    endcase
  endfunction

  task automatic sync_frame();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  task automatic run_case(input int u, input int a, input int b, input bit ip);
    string tg;
    sync_frame();
    vc1 = VW'(a); vc2 = VW'(b); cur_pos = ip; uref = '0;
    repeat (TS) @(negedge clk);
    check("R10 frame_start at period start", int'(frame_start), 1);
    uref = (VW+2)'(u);
    for (int c = 0; c < TS; c++) begin
      // R9: this period was sampled with uref=0, so it stays middle/middle
      check("R9 new ref ignored within period", int'(gate_a) * 16 + int'(gate_b), GO * 16 + GO);
      @(negedge clk);
    end
    for (int c = 0; c < TS; c++) begin
      if (c == 1) check("R10 frame_start single", int'(frame_start), 0);
      tg = (a == b) ? "R7 equal caps" : (u > (a+b)/2 || u < -((a+b)/2)) ? "R3/R4 outer section" :
           "R4/R5/R6 inner section";
      check(tg, int'(gate_a) * 16 + int'(gate_b), exp_pair(c, u, a, b, ip));
      @(negedge clk);
    end
  endtask

  task automatic hold_case(input int u, input int a, input int b, input bit ip, input int flipc);
    sync_frame();
    vc1 = VW'(a); vc2 = VW'(b); cur_pos = ip; uref = '0;
    repeat (TS) @(negedge clk);
    uref = (VW+2)'(u);
    repeat (TS) @(negedge clk);
    for (int c = 0; c < TS; c++) begin
      if (c == flipc) cur_pos = !ip;
      check("R8 hold during half dwell", int'(gate_a) * 16 + int'(gate_b), exp_pair(c, u, a, b, ip));
      @(negedge clk);
    end
    for (int c = 0; c < TS; c++) begin
      check("R8 follow after release", int'(gate_a) * 16 + int'(gate_b), exp_pair(c, u, a, b, !ip));
      @(negedge clk);
    end
  endtask

  initial begin
    int cfg_a [4] = '{40, 24, 32, 31};
    int cfg_b [4] = '{24, 40, 32, 32};
    repeat (3) @(negedge clk);
    check("R1 reset gate_a", int'(gate_a), GO);
    check("R1 reset gate_b", int'(gate_b), GO);
    check("R1 reset frame_start", int'(frame_start), 1);
    rst_n = 1'b1;
    for (int c = 0; c < TS; c++) begin
      check("R1 first period middle", int'(gate_a) * 16 + int'(gate_b), GO * 16 + GO);
      check("R2 legal middle code", int'(gate_a), GO);
      @(negedge clk);
    end
    hold_case(20, 40, 24, 1'b1, 9);
    hold_case(-20, 40, 24, 1'b0, 9);
    hold_case(20, 24, 40, 1'b0, 10);
    for (int k = 0; k < 4; k++)
      for (int u = -(cfg_a[k] + cfg_b[k]) - 2; u <= cfg_a[k] + cfg_b[k] + 2; u++)
        for (int ip = 0; ip < 2; ip++)
          run_case(u, cfg_a[k], cfg_b[k], ip[0]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired before completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule